// File: doc/BRIEF.md
# FDDI Transmit Symbol Encoder

This block turns byte-wide transmit requests into a serial FDDI line stream. Each request word holds two 4-bit symbols, a control flag and an odd-parity bit. The word is screened for parity and for symbols with no defined meaning, and each symbol is mapped to its 5-bit code group. The resulting pair of code groups is shifted out one bit per clock, most significant bit first. NRZI coding can be switched on for that stream.

A small set of control inputs sets the behaviour. They can replace the data with a commanded line-state symbol pair, enable or disable the parity screen and NRZI, and steer the serial stream to one of three outputs: the media transmitter, the internal receive loopback or the clock-recovery loopback. A faulty word is never sent. A Halt pair goes out in its place, and a sticky error flag records the event.

The block takes a new word every ten clocks and pulses a strobe in the cycle before each take. Line-state changes therefore act only on whole symbol pairs.

Top module: `fddi_tx_encoder`

## Requirements
- R1: After reset, all three serial outputs, `err_flag` and `word_take` are 0.
- R2: `req_word` is laid out as {control, parity, first nibble [7:4], second nibble [3:0]}. With control 0, each nibble value 0..F maps to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. The first symbol's code is sent first, and each code is sent MSB first.
- R3: With control 1, nibble values 0..7 map to the control symbols Quiet 00000, Idle 11111, Halt 00100, J 11000, K 10001, T 01101, R 00111 and S 11001.
- R4: Parity is odd across all 10 bits. With `par_chk_en`=1, a word with even parity is sent as Halt-Halt (00100 00100) and sets `err_flag`. With `par_chk_en`=0, it is encoded normally and leaves `err_flag` unchanged.
- R5: With control 1, nibble values 8..F are violations. The word is sent as Halt-Halt and sets `err_flag`. No code outside the defined set reaches the line.
- R6: `ls_sel` picks the pair source: 0 = data, 1 = Idle pair, 2 = Master (Halt then Quiet), 3 = Halt pair, 4 = Quiet pair, 5 = `user_pair` (bits [9:5] sent first). The values 6 and 7 act as Idle. The choice is sampled only when a word is taken.
- R7: While `ls_sel` is not 0, `req_word` has no effect on the line or on `err_flag`.
- R8: With `nrzi_en`=1, the output level toggles for each 1 bit and holds for each 0 bit. With `nrzi_en`=0, the output equals the code bit.
- R9: `route` selects the output that carries the stream: 0 or 3 = `pmd_tx`, 1 = `lb_int`, 2 = `lb_ext`. The unselected outputs are held at 0.
- R10: `err_flag` stays set until `err_clr` is asserted. A new error in the same cycle as `err_clr` wins, and the flag stays set.
- R11: `word_take` is high for one cycle in every ten. The word and controls present in that cycle are loaded at the following edge. The first code bit appears on the output one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_word | input | 10 | Transmit request word |
| word_take | output | 1 | High in the cycle whose inputs are loaded next |
| ls_sel | input | 3 | Line-state / pair source select |
| user_pair | input | 10 | Programmable symbol pair |
| par_chk_en | input | 1 | Parity screening enable |
| nrzi_en | input | 1 | NRZI coding enable |
| route | input | 2 | Output steering select |
| err_clr | input | 1 | Clears the sticky error flag |
| pmd_tx | output | 1 | Serial stream to the media transmitter |
| lb_int | output | 1 | Serial stream to the internal receive loopback |
| lb_ext | output | 1 | Serial stream to the clock-recovery loopback |
| err_flag | output | 1 | Sticky flag for parity or violation errors |

## Verification
Setting the error flag and clearing it can fall in the same cycle. This happens when a faulty word is taken while `err_clr` is high. The bench provokes it by sending an even-parity data word with `err_clr` asserted through the load edge. The flag must still read 1 afterwards, and a later clear on a cycle with no load must bring it to 0. A second coincidence is a line-state override arriving together with a faulty word. The bench sends such a word under an Idle override and judges that both the line and the flag ignore it.

// File: rtl/fddi_tx_pkg.sv
package fddi_tx_pkg;

    localparam int NIB_W  = 4;
    localparam int SYM_W  = 5;
    localparam int PAIR_W = 2 * SYM_W;
    localparam int WORD_W = 2 * NIB_W + 2;

    localparam logic [SYM_W-1:0] CG_QUIET = 5'b00000;
    localparam logic [SYM_W-1:0] CG_IDLE  = 5'b11111;
    localparam logic [SYM_W-1:0] CG_HALT  = 5'b00100;
    localparam logic [SYM_W-1:0] CG_J     = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K     = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T     = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R     = 5'b00111;
    localparam logic [SYM_W-1:0] CG_S     = 5'b11001;

    typedef enum logic [2:0] {
        LS_DATA   = 3'd0,
        LS_IDLE   = 3'd1,
        LS_MASTER = 3'd2,
        LS_HALT   = 3'd3,
        LS_QUIET  = 3'd4,
        LS_USER   = 3'd5
    } ls_e;

    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_INT    = 2'd1,
        RT_EXT    = 2'd2
    } route_e;

    typedef struct packed {
        logic             viol;
        logic [SYM_W-1:0] code;
    } sym_t;

    function automatic sym_t enc_sym(input logic ctl, input logic [NIB_W-1:0] nib);
        sym_t s;
        s.viol = 1'b0;
        s.code = CG_HALT;
        if (!ctl) begin
            case (nib)
                4'h0: s.code = 5'b11110;
                4'h1: s.code = 5'b01001;
                4'h2: s.code = 5'b10100;
                4'h3: s.code = 5'b10101;
                4'h4: s.code = 5'b01010;
                4'h5: s.code = 5'b01011;
                4'h6: s.code = 5'b01110;
                4'h7: s.code = 5'b01111;
                4'h8: s.code = 5'b10010;
                4'h9: s.code = 5'b10011;
                4'hA: s.code = 5'b10110;
                4'hB: s.code = 5'b10111;
                4'hC: s.code = 5'b11010;
                4'hD: s.code = 5'b11011;
                4'hE: s.code = 5'b11100;
                default: s.code = 5'b11101;
            endcase
        end else begin
            case (nib)
                4'h0: s.code = CG_QUIET;
                4'h1: s.code = CG_IDLE;
                4'h2: s.code = CG_HALT;
                4'h3: s.code = CG_J;
                4'h4: s.code = CG_K;
                4'h5: s.code = CG_T;
                4'h6: s.code = CG_R;
                4'h7: s.code = CG_S;
                default: s.viol = 1'b1;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/fddi_sym_map.sv
module fddi_sym_map
    import fddi_tx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              par_chk_en,
    output logic [PAIR_W-1:0] pair,
    output logic              bad
);
    localparam int NSYM = 2;

    logic             ctl;
    logic             par_ok;
    logic [NSYM-1:0]  viol;

    assign ctl    = word[WORD_W-1];
    assign par_ok = ^word;

    for (genvar i = 0; i < NSYM; i++) begin : g_sym
        sym_t s;
        always_comb begin
            s = enc_sym(ctl, word[i*NIB_W +: NIB_W]);
        end
        assign pair[i*SYM_W +: SYM_W] = s.code;
        assign viol[i]                = s.viol;
    end

    assign bad = (|viol) | (par_chk_en & ~par_ok);

endmodule

// File: rtl/fddi_pair_sel.sv
module fddi_pair_sel
    import fddi_tx_pkg::*;
(
    input  logic [2:0]        ls_sel,
    input  logic [PAIR_W-1:0] user_pair,
    input  logic [PAIR_W-1:0] data_pair,
    input  logic              data_bad,
    output logic [PAIR_W-1:0] pair,
    output logic              err_set
);
    always_comb begin
        err_set = 1'b0;
        case (ls_e'(ls_sel))
            LS_DATA: begin
                pair    = data_bad ? {CG_HALT, CG_HALT} : data_pair;
                err_set = data_bad;
            end
            LS_IDLE:   pair = {CG_IDLE, CG_IDLE};
            LS_MASTER: pair = {CG_HALT, CG_QUIET};
            LS_HALT:   pair = {CG_HALT, CG_HALT};
            LS_QUIET:  pair = {CG_QUIET, CG_QUIET};
            LS_USER:   pair = user_pair;
            default:   pair = {CG_IDLE, CG_IDLE};
        endcase
    end

endmodule

// File: rtl/fddi_serializer.sv
module fddi_serializer #(
    parameter int PAIR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] load_pair,
    input  logic              nrzi_en,
    output logic              word_take,
    output logic              tx_bit
);
    localparam int CNT_W = $clog2(PAIR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIR_W - 1);

    typedef struct packed {
        logic [PAIR_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              tx;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.sh  = load_pair;
            st_d.cnt = '0;
        end else begin
            st_d.sh  = {st_q.sh[PAIR_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.tx = nrzi_en ? (st_q.tx ^ st_q.sh[PAIR_W-1]) : st_q.sh[PAIR_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_take = (st_q.cnt == LAST);
    assign tx_bit    = st_q.tx;

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |=> !word_take); // R11

    AST_NRZ_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nrzi_en && !st_q.sh[PAIR_W-1]) |=> $stable(tx_bit)); // R8

endmodule

// File: rtl/fddi_tx_encoder.sv
module fddi_tx_encoder
    import fddi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] req_word,
    output logic              word_take,
    input  logic [2:0]        ls_sel,
    input  logic [PAIR_W-1:0] user_pair,
    input  logic              par_chk_en,
    input  logic              nrzi_en,
    input  logic [1:0]        route,
    input  logic              err_clr,
    output logic              pmd_tx,
    output logic              lb_int,
    output logic              lb_ext,
    output logic              err_flag
);
    logic [PAIR_W-1:0] data_pair;
    logic              data_bad;
    logic [PAIR_W-1:0] sel_pair;
    logic              err_set;
    logic              tx_bit;
    logic              err_d, err_q;

    fddi_sym_map u_map (
        .word       (req_word),
        .par_chk_en (par_chk_en),
        .pair       (data_pair),
        .bad        (data_bad)
    );

    fddi_pair_sel u_sel (
        .ls_sel    (ls_sel),
        .user_pair (user_pair),
        .data_pair (data_pair),
        .data_bad  (data_bad),
        .pair      (sel_pair),
        .err_set   (err_set)
    );

    fddi_serializer #(.PAIR_W(PAIR_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_pair (sel_pair),
        .nrzi_en   (nrzi_en),
        .word_take (word_take),
        .tx_bit    (tx_bit)
    );

    always_comb begin
        err_d = err_q;
        if (word_take && err_set) err_d = 1'b1;
        else if (err_clr)         err_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_flag = err_q;
    assign lb_int   = (route == RT_INT) & tx_bit;
    assign lb_ext   = (route == RT_EXT) & tx_bit;
    assign pmd_tx   = ((route != RT_INT) && (route != RT_EXT)) & tx_bit;

    AST_BAD_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take && ls_sel == LS_DATA && data_bad) |-> sel_pair == {CG_HALT, CG_HALT}); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R10

    AST_OVR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !(word_take && ls_sel == LS_DATA)) |=> !err_flag); // R7

    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pmd_tx, lb_int, lb_ext}) <= 1); // R9

endmodule

// File: tb/test_fddi_tx_encoder.sv
module test_fddi_tx_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req_word = '0;
    logic       word_take;
    logic [2:0] ls_sel = 3'd1;
    logic [9:0] user_pair = '0;
    logic       par_chk_en = 1'b1;
    logic       nrzi_en = 1'b0;
    logic [1:0] route = 2'd0;
    logic       err_clr = 1'b0;
    logic       pmd_tx, lb_int, lb_ext, err_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fddi_tx_encoder i_fddi_tx_encoder (
        .clk(clk), .rst_n(rst_n), .req_word(req_word), .word_take(word_take),
        .ls_sel(ls_sel), .user_pair(user_pair), .par_chk_en(par_chk_en),
        .nrzi_en(nrzi_en), .route(route), .err_clr(err_clr),
        .pmd_tx(pmd_tx), .lb_int(lb_int), .lb_ext(lb_ext), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic [4:0] dcode(input [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                               5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic [9:0] mk(input bit c, input [3:0] hi, input [3:0] lo, input bit good);
        logic p;
        p = ~^{c, hi, lo};
        if (!good) p = ~p;
        return {c, p, hi, lo};
    endfunction

    function automatic logic sel_out();
        if (route == 2'd1) return lb_int;
        if (route == 2'd2) return lb_ext;
        return pmd_tx;
    endfunction

    task automatic wait_take();
        @(negedge clk);
        while (!word_take) @(negedge clk);
    endtask

    // Loads one pair and compares the serial bits on the routed output.
    task automatic send(input [9:0] w, input [2:0] ls, input bit clr,
                        input [9:0] exp, input string tag);
        int bad_bits;
        logic lvl, o;
        bad_bits = 0;
        wait_take();
        req_word = w; ls_sel = ls; err_clr = clr;
        @(posedge clk);
        @(negedge clk);
        lvl = sel_out();
        req_word = mk(1'b0, 4'h0, 4'h0, 1'b1); ls_sel = 3'd1; err_clr = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            o = sel_out();
            lvl = nrzi_en ? (lvl ^ exp[9-k]) : exp[9-k];
            if (o !== lvl) bad_bits++;
            if (pmd_tx + lb_int + lb_ext > 1) bad_bits++;
        end
        chk(bad_bits == 0, tag, bad_bits, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pmd_tx == 0 && lb_int == 0 && lb_ext == 0, "R1 outputs", pmd_tx, 0);
        chk(err_flag == 0, "R1 err_flag", err_flag, 0);
        chk(word_take == 0, "R1 word_take", word_take, 0);
    endtask

    task automatic t_cadence();
        int gap;
        wait_take();
        gap = 0;
        @(negedge clk); gap++;
        while (!word_take) begin @(negedge clk); gap++; end
        chk(gap == 10, "R11 take interval", gap, 10);
    endtask

    task automatic t_data();
        send(mk(1'b0, 4'hA, 4'h5, 1'b1), 3'd0, 1'b0, {dcode(4'hA), dcode(4'h5)}, "R2 data A5");
        send(mk(1'b0, 4'h0, 4'hF, 1'b1), 3'd0, 1'b0, {dcode(4'h0), dcode(4'hF)}, "R2 data 0F");
        send(mk(1'b0, 4'h3, 4'hC, 1'b1), 3'd0, 1'b0, {dcode(4'h3), dcode(4'hC)}, "R2 data 3C");
        chk(err_flag == 0, "R2 no error on good data", err_flag, 0);
    endtask

    task automatic t_ctl();
        send(mk(1'b1, 4'h3, 4'h4, 1'b1), 3'd0, 1'b0, {5'b11000, 5'b10001}, "R3 J K");
        send(mk(1'b1, 4'h5, 4'h6, 1'b1), 3'd0, 1'b0, {5'b01101, 5'b00111}, "R3 T R");
        send(mk(1'b1, 4'h7, 4'h2, 1'b1), 3'd0, 1'b0, {5'b11001, 5'b00100}, "R3 S H");
        chk(err_flag == 0, "R3 no error on control", err_flag, 0);
    endtask

    task automatic t_parity();
        par_chk_en = 1'b0;
        send(mk(1'b0, 4'h6, 4'h9, 1'b0), 3'd0, 1'b0, {dcode(4'h6), dcode(4'h9)}, "R4 check off");
        chk(err_flag == 0, "R4 no error with check off", err_flag, 0);
        par_chk_en = 1'b1;
        send(mk(1'b0, 4'h6, 4'h9, 1'b0), 3'd0, 1'b0, 10'b00100_00100, "R4 bad parity halt");
        chk(err_flag == 1, "R4 error set", err_flag, 1);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_viol();
        chk(err_flag == 0, "R5 precondition clear", err_flag, 0);
        send(mk(1'b1, 4'h9, 4'h1, 1'b1), 3'd0, 1'b0, 10'b00100_00100, "R5 violation halt");
        chk(err_flag == 1, "R5 error set", err_flag, 1);
    endtask

    task automatic t_sticky();
        send(mk(1'b0, 4'h1, 4'h1, 1'b0), 3'd0, 1'b1, 10'b00100_00100, "R10 set with clear");
        chk(err_flag == 1, "R10 set wins over clear", err_flag, 1);
        repeat (12) @(negedge clk);
        chk(err_flag == 1, "R10 flag holds", err_flag, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk(err_flag == 0, "R10 flag cleared", err_flag, 0);
    endtask

    task automatic t_ls();
        user_pair = 10'b10110_01001;
        send(10'h000, 3'd1, 1'b0, 10'b11111_11111, "R6 idle");
        send(10'h000, 3'd2, 1'b0, 10'b00100_00000, "R6 master");
        send(10'h000, 3'd3, 1'b0, 10'b00100_00100, "R6 halt");
        send(10'h000, 3'd4, 1'b0, 10'b00000_00000, "R6 quiet");
        send(10'h000, 3'd5, 1'b0, 10'b10110_01001, "R6 user pair");
        send(10'h000, 3'd7, 1'b0, 10'b11111_11111, "R6 code 7 as idle");
    endtask

    task automatic t_override();
        chk(err_flag == 0, "R7 precondition clear", err_flag, 0);
        send(mk(1'b1, 4'hF, 4'hE, 1'b0), 3'd1, 1'b0, 10'b11111_11111, "R7 faulty word under idle");
        chk(err_flag == 0, "R7 err untouched", err_flag, 0);
    endtask

    task automatic t_nrzi();
        nrzi_en = 1'b1;
        send(mk(1'b0, 4'hA, 4'h5, 1'b1), 3'd0, 1'b0, {dcode(4'hA), dcode(4'h5)}, "R8 nrzi data");
        send(10'h000, 3'd1, 1'b0, 10'b11111_11111, "R8 nrzi idle toggles");
        nrzi_en = 1'b0;
    endtask

    task automatic t_route();
        route = 2'd1;
        send(mk(1'b0, 4'h2, 4'h7, 1'b1), 3'd0, 1'b0, {dcode(4'h2), dcode(4'h7)}, "R9 internal loop");
        route = 2'd2;
        send(mk(1'b0, 4'hB, 4'h4, 1'b1), 3'd0, 1'b0, {dcode(4'hB), dcode(4'h4)}, "R9 external loop");
        route = 2'd3;
        send(10'h000, 3'd1, 1'b0, 10'b11111_11111, "R9 code 3 as normal");
        route = 2'd1;
        send(10'h000, 3'd1, 1'b0, 10'b11111_11111, "R9 idle on lb_int");
        @(negedge clk);
        chk(pmd_tx == 0 && lb_ext == 0, "R9 unselected low", {pmd_tx, lb_ext}, 0);
        route = 2'd0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        req_word = mk(1'b0, 4'h0, 4'h0, 1'b1);
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_cadence();
        t_data();
        t_ctl();
        t_parity();
        t_viol();
        t_sticky();
        t_ls();
        t_override();
        t_nrzi();
        t_route();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule